// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block acts as an I2C target in front of a 2K x 8 byte-addressed memory. SCL and SDA are sampled with the system clock. It finds Start and Stop conditions on the sampled lines and decodes the select byte and the following word-address byte. It supports five operations: single-byte store, multi-byte page store, read at the current address, random read and streaming read. One address counter is shared by reads and writes and persists from one transfer to the next. SDA is never driven high: the block only asserts a pull-low enable, and an external pull-up resolves the line.

Written bytes are not stored right away. They go into a page buffer inside a page-write engine. The buffer is committed only when the master closes the write with a Stop placed directly after a data-byte acknowledge. The commit starts a timed write cycle. For its whole length the block ignores the bus completely, so a master can repeat Start plus select and wait for the first ACK. A write-protect input lets select and address bytes through but refuses every data byte.

Top module: `serial_eeprom_target`

## Requirements
- R1: After reset SDA is released, the address counter is 000h and every memory byte reads FFh.
- R2: Bits are taken on SCL rising edges, MSB first. A select byte with 1010 in bits 7:4 is acknowledged by pulling SDA low during the 9th clock. Its bits 3:1 give address bits 10:8 and bit 0 is R/W (1 = read). Any other select byte gets no ACK, and the block then ignores the bus until the next Start.
- R3: A write select, an address byte carrying address bits 7:0 and one data byte, followed by a Stop directly after the data ACK, store that byte at the address.
- R4: In a page write, each further data byte goes to the next offset within the same 16-byte page and wraps from offset 15 to offset 0. All of them are stored at the Stop.
- R5: A Start after data bytes, or a Stop in any other bit slot, stores nothing.
- R6: With write-protect high, the select and address bytes are acknowledged, every data byte gets NoAck, memory is unchanged and no write cycle starts.
- R7: For WR_CYCLES clock cycles after a commit the block gives no ACK, not even to its own select code. After that it acknowledges again.
- R8: A write select plus an address byte, then a repeated Start and a read select, returns the byte at the loaded address.
- R9: A read select on its own returns the byte at the counter. The counter advances by one after every byte sent. After a write it points to the byte after the last written one, within the same page.
- R10: During a read, a master ACK brings the next byte and a master NoAck releases SDA and ends the transfer. The counter wraps from 7FFh to 000h.
- R11: Reads work the same whether write-protect is high or low.
- R12: Start is SDA falling while SCL is high and Stop is SDA rising while SCL is high. A Stop always releases SDA, and a repeated Start restarts select decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Resolved data line as seen at the pad |
| wr_protect | input | 1 | High refuses data bytes of write transfers |
| sda_pull_low | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
The Stop that commits a page and the opening of the deaf write window can fall in the same cycle. At that point the engine takes the commit just as the target drops back to idle. The bench provokes this by polling with Start plus select straight after every committing Stop. It judges the result by requiring that the first poll gets NoAck and that the first ACK comes no earlier than the write-cycle length after the Stop. It also polls straight after a write-protected transfer and after an aborted one, where the first poll must be acknowledged because nothing was committed.

// File: rtl/seep_pkg.sv
package seep_pkg;
    localparam logic [3:0] SEL_CODE = 4'b1010;
    localparam int         BYTE_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic code_match(input logic [7:0] b);
        return b[7:4] == SEL_CODE;
    endfunction
endpackage

// File: rtl/seep_line_sync.sv
module seep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output seep_pkg::bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_s, sda_s, scl_q, sda_q;

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    always_comb begin
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/seep_page_engine.sv
module seep_page_engine #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 1500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [7:0]        push_data,
    input  logic              discard,
    input  logic              commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;
    localparam int PG_W  = ADDR_W - PAGE_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [7:0]      mem  [DEPTH];
    logic [7:0]      pbuf [PAGE];
    logic [PAGE-1:0] pvalid;
    logic [PG_W-1:0] page_q;
    logic [CNT_W-1:0] wcnt;
    logic            do_commit;

    assign do_commit = commit && (pvalid != '0);
    assign busy      = (wcnt != '0);
    assign rd_data   = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            pvalid <= '0;
            page_q <= '0;
            wcnt   <= '0;
        end else begin
            if (do_commit) begin
                for (int i = 0; i < PAGE; i++) begin
                    if (pvalid[i]) mem[{page_q, PAGE_W'(i)}] <= pbuf[i];
                end
                pvalid <= '0;
                wcnt   <= CNT_W'(WR_CYCLES);
            end else begin
                if (wcnt != '0) wcnt <= wcnt - CNT_W'(1);
                if (commit || discard) begin
                    pvalid <= '0;
                end else if (push) begin
                    pbuf[push_addr[PAGE_W-1:0]]   <= push_data;
                    pvalid[push_addr[PAGE_W-1:0]] <= 1'b1;
                    page_q                        <= push_addr[ADDR_W-1:PAGE_W];
                end
            end
        end
    end

    AST_NO_PUSH_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !push && !commit); // R7
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
        (push && pvalid != '0) |-> push_addr[ADDR_W-1:PAGE_W] == page_q); // R4
endmodule

// File: rtl/seep_bus_fsm.sv
module seep_bus_fsm #(
    parameter int BLK_W  = 3,
    parameter int PAGE_W = 4,
    localparam int ADDR_W = BLK_W + 8
) (
    input  logic              clk,
    input  logic              rst,
    input  seep_pkg::bus_ev_t ev,
    input  logic              wr_protect,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] ctr,
    output logic              sda_oe,
    output logic              push,
    output logic [ADDR_W-1:0] push_addr,
    output logic [7:0]        push_data,
    output logic              discard,
    output logic              commit
);
    import seep_pkg::*;

    phase_e           state, nxt;
    logic [3:0]       bitcnt;
    logic             ackph, mack;
    logic [7:0]       sr, tx;
    logic [BLK_W-1:0] blk;

    always_ff @(posedge clk) begin
        push    <= 1'b0;
        discard <= 1'b0;
        commit  <= 1'b0;
        if (rst) begin
            state     <= ST_IDLE;
            nxt       <= ST_IDLE;
            bitcnt    <= '0;
            ackph     <= 1'b0;
            mack      <= 1'b0;
            sr        <= '0;
            tx        <= '0;
            blk       <= '0;
            ctr       <= '0;
            sda_oe    <= 1'b0;
            push_addr <= '0;
            push_data <= '0;
        end else if (busy) begin
            state  <= ST_IDLE;
            ackph  <= 1'b0;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_SEL;
            bitcnt  <= '0;
            ackph   <= 1'b0;
            sda_oe  <= 1'b0;
            discard <= 1'b1;
        end else if (ev.stop) begin
            if (state == ST_WDATA && bitcnt == 4'd1 && !ackph) commit <= 1'b1;
            else discard <= 1'b1;
            state  <= ST_IDLE;
            ackph  <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RDATA: begin
                    if (ev.rise) begin
                        if (ackph) mack <= ~ev.sda;
                        else if (bitcnt < 4'd8) begin
                            bitcnt <= bitcnt + 4'd1;
                            tx     <= {tx[6:0], 1'b0};
                        end
                    end
                    if (ev.fall) begin
                        if (ackph) begin
                            ackph  <= 1'b0;
                            bitcnt <= '0;
                            if (mack) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ctr    <= ctr + ADDR_W'(1);
                            end else begin
                                state  <= ST_IDLE;
                                sda_oe <= 1'b0;
                            end
                        end else if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            ackph  <= 1'b1;
                        end else begin
                            sda_oe <= ~tx[7];
                        end
                    end
                end
                ST_SEL, ST_ADDR, ST_WDATA: begin
                    if (ev.rise && !ackph && bitcnt < 4'd8) begin
                        sr     <= {sr[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (ev.fall) begin
                        if (ackph) begin
                            ackph  <= 1'b0;
                            bitcnt <= '0;
                            state  <= nxt;
                            if (nxt == ST_RDATA) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ctr    <= ctr + ADDR_W'(1);
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end else if (bitcnt == 4'd8) begin
                            if (state == ST_SEL) begin
                                if (code_match(sr)) begin
                                    ackph  <= 1'b1;
                                    sda_oe <= 1'b1;
                                    blk    <= sr[BLK_W:1];
                                    nxt    <= sr[0] ? ST_RDATA : ST_ADDR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_ADDR) begin
                                ackph  <= 1'b1;
                                sda_oe <= 1'b1;
                                ctr    <= {blk, sr};
                                nxt    <= ST_WDATA;
                            end else begin
                                ackph <= 1'b1;
                                nxt   <= ST_WDATA;
                                if (!wr_protect) begin
                                    sda_oe    <= 1'b1;
                                    push      <= 1'b1;
                                    push_addr <= ctr;
                                    push_data <= sr;
                                    ctr <= {ctr[ADDR_W-1:PAGE_W], ctr[PAGE_W-1:0] + PAGE_W'(1)};
                                end
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe); // R7
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe); // R12
    AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= 4'd8); // R2
    AST_MASTER_ACK_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDATA && ackph) |-> !sda_oe); // R10
endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target #(
    parameter int BLK_W       = 3,
    parameter int PAGE_W      = 4,
    parameter int WR_CYCLES   = 1500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic wr_protect,
    output logic sda_pull_low
);
    localparam int ADDR_W = BLK_W + 8;

    seep_pkg::bus_ev_t ev;
    logic              busy, push, discard, commit;
    logic [ADDR_W-1:0] ctr, push_addr;
    logic [7:0]        push_data, rd_data;

    seep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    seep_bus_fsm #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_fsm (
        .clk(clk), .rst(rst), .ev(ev), .wr_protect(wr_protect), .busy(busy),
        .rd_data(rd_data), .ctr(ctr), .sda_oe(sda_pull_low), .push(push),
        .push_addr(push_addr), .push_data(push_data), .discard(discard),
        .commit(commit)
    );

    seep_page_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_engine (
        .clk(clk), .rst(rst), .push(push), .push_addr(push_addr),
        .push_data(push_data), .discard(discard), .commit(commit),
        .rd_addr(ctr), .rd_data(rd_data), .busy(busy)
    );

    AST_WP_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        $past(wr_protect) |-> !push); // R6
endmodule

// File: tb/serial_eeprom_target_bench.sv
module serial_eeprom_target_bench;
    localparam int WR_CYCLES = 1500;
    localparam int DEPTH     = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic wp = 1'b0;
    wire  dut_low;
    wire  sda_line = !(m_low | dut_low);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    logic [7:0]  model [DEPTH];
    logic [10:0] cnt_m;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_eeprom_target #(.WR_CYCLES(WR_CYCLES)) u_serial_eeprom_target (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .wr_protect(wp), .sda_pull_low(dut_low)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'((a * 7 + salt * 29 + 5) & 255);
    endfunction

    task automatic bus_start();
        m_low = 1'b0; hold(8);
        scl = 1'b1;   hold(8);
        m_low = 1'b1; hold(8);
        scl = 1'b0;   hold(8);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; hold(8);
        scl = 1'b1;   hold(8);
        m_low = 1'b0; hold(16);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i]; hold(8);
            scl = 1'b1;    hold(16);
            scl = 1'b0;    hold(8);
        end
        m_low = 1'b0; hold(8);
        scl = 1'b1;   hold(8);
        ack = !sda_line;
        hold(8);
        scl = 1'b0;   hold(8);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        for (int i = 7; i >= 0; i--) begin
            hold(8);
            scl = 1'b1; hold(8);
            b[i] = sda_line;
            hold(8);
            scl = 1'b0;
        end
        hold(8);
        m_low = give_ack; hold(8);
        scl = 1'b1; hold(16);
        scl = 1'b0; hold(8);
        m_low = 1'b0;
    endtask

    task automatic write_seq(input logic [10:0] a, input int n, input int salt, input string req);
        logic ack;
        logic [10:0] t;
        logic [7:0] d;
        bus_start();
        send_byte({4'hA, a[10:8], 1'b0}, ack);
        check(ack == 1'b1, req, ack, 1);
        send_byte(a[7:0], ack);
        check(ack == 1'b1, req, ack, 1);
        cnt_m = a;
        for (int k = 0; k < n; k++) begin
            t = {a[10:4], 4'(a[3:0] + 4'(k))};
            d = pat(int'(t), salt);
            send_byte(d, ack);
            check(ack == !wp, req, ack, !wp);
            if (!wp) begin
                model[t] = d;
                cnt_m = {t[10:4], 4'(t[3:0] + 4'd1)};
            end
        end
        bus_stop();
    endtask

    task automatic wait_ready(input string req, input bit expect_busy);
        logic ack;
        int tries;
        int t0;
        t0 = cyc;
        tries = 0;
        ack = 1'b0;
        for (int p = 0; p < 200 && !ack; p++) begin
            bus_start();
            send_byte(8'hA0, ack);
            bus_stop();
            if (!ack) tries++;
        end
        check(ack == 1'b1, req, ack, 1);
        if (expect_busy) begin
            check(tries >= 1, req, tries, 1);
            check((cyc - t0) >= WR_CYCLES - 64, req, cyc - t0, WR_CYCLES);
        end else begin
            check(tries == 0, req, tries, 0);
        end
    endtask

    task automatic read_body(input int n, input string req);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k != n - 1);
            check(b == model[cnt_m], req, b, model[cnt_m]);
            cnt_m = cnt_m + 11'd1;
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [10:0] a, input int n, input string req);
        logic ack;
        bus_start();
        send_byte({4'hA, a[10:8], 1'b0}, ack);
        check(ack == 1'b1, req, ack, 1);
        send_byte(a[7:0], ack);
        cnt_m = a;
        bus_start();
        send_byte(8'hA1, ack);
        check(ack == 1'b1, req, ack, 1);
        read_body(n, req);
    endtask

    task automatic cur_read(input int n, input string req);
        logic ack;
        bus_start();
        send_byte(8'hA1, ack);
        check(ack == 1'b1, req, ack, 1);
        read_body(n, req);
    endtask

    initial begin
        logic ack;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        cnt_m = '0;
        hold(10);
        rst = 1'b0;
        hold(10);
        check(dut_low == 1'b0, "R1", dut_low, 0);
        cur_read(2, "R1");

        // R2: sweep every upper nibble of the select byte
        for (int n = 0; n < 16; n++) begin
            bus_start();
            send_byte({4'(n), 3'b000, 1'b0}, ack);
            check(ack == (n == 10), "R2", ack, (n == 10));
            send_byte(8'h00, ack);
            check(ack == (n == 10), "R2", ack, (n == 10));
            if (n == 10) cnt_m = '0;
            bus_stop();
        end
        wait_ready("R5", 1'b0);

        write_seq(11'h123, 1, 1, "R3");
        wait_ready("R7", 1'b1);
        rand_read(11'h123, 1, "R3");

        write_seq(11'h25C, 7, 3, "R4");
        wait_ready("R7", 1'b1);
        cur_read(1, "R9");
        rand_read(11'h250, 16, "R4");
        cur_read(2, "R9");

        // R5: repeated Start after an acknowledged data byte discards it
        bus_start();
        send_byte(8'hA6, ack);
        send_byte(8'h30, ack);
        send_byte(8'h5A, ack);
        check(ack == 1'b1, "R5", ack, 1);
        bus_start();
        bus_stop();
        wait_ready("R5", 1'b0);
        rand_read(11'h330, 1, "R5");

        wp = 1'b1;
        write_seq(11'h345, 2, 5, "R6");
        wait_ready("R6", 1'b0);
        rand_read(11'h345, 2, "R11");
        rand_read(11'h250, 3, "R11");
        wp = 1'b0;

        write_seq(11'h7FF, 1, 7, "R3");
        wait_ready("R7", 1'b1);
        write_seq(11'h000, 1, 9, "R3");
        wait_ready("R7", 1'b1);
        rand_read(11'h7FF, 3, "R10");
        check(dut_low == 1'b0, "R10", dut_low, 0);
        cur_read(1, "R9");
        rand_read(11'h25E, 4, "R8");
        check(dut_low == 1'b0, "R12", dut_low, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule